// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 38-bit logical address into a physical address. It walks a two-level page table that sits in memory. A request carries the logical address and a flag that marks it as a write. The walker then fetches one 32-bit directory entry and one 32-bit table entry over a single-word read port. It answers with either the physical address or a fault code. The logical address divides into three fields, from the top bit down:

- a 12-bit directory index in bits [37:26],
- a 12-bit table index in bits [25:14],
- a 14-bit byte offset in bits [13:0], which gives 16 KB pages.

Each table holds 4096 entries of 4 bytes, so one table fills exactly one 16 KB frame.

Every entry holds a 24-bit frame number and eight control bits. Frames are 16 KB aligned, so a frame's byte address is its frame number followed by 14 zero bits. A plain input gives the frame that holds the page directory.

The request port and the response port both use valid/ready. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. Once the response is presented, it stays unchanged until the consumer raises `rsp_ready`. The memory read request follows the same rule: it holds address and valid until `mem_rd_ready`. The read data returns later on a one-cycle `mem_rsp_valid` pulse. The walker always waits for that pulse, however long it takes.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle, with no walk in flight and no response pending. A request is taken when `req_valid` and `req_ready` are both high; `req_ready` is low in the cycle after that.
- R2: The first memory read goes to address (D << 14) + 4 × vaddr[37:26], where D is the value of `dir_base_frame` at the moment the request was taken. Later changes to `dir_base_frame` do not affect the walk in progress.
- R3: The second memory read goes to address (F << 14) + 4 × vaddr[25:14], where F is bits [31:8] of the directory entry.
- R4: `mem_rd_valid` and `mem_rd_addr` stay unchanged until `mem_rd_ready` is seen. The walker then waits any number of cycles for `mem_rsp_valid`.
- R5: If bit 0 (present) of the directory entry is clear, the walk ends with `rsp_status` = 1 (absent) and `rsp_level` = 0. `rsp_paddr` is then 0, and no second memory read is issued.
- R6: If bit 0 of the table entry is clear, the walk ends with `rsp_status` = 1, `rsp_level` = 1 and `rsp_paddr` = 0.
- R7: A write request whose present table entry has bit 1 (writable) clear ends with `rsp_status` = 2 (protection), `rsp_level` = 1 and `rsp_paddr` = 0. A read request to the same entry succeeds.
- R8: On success, `rsp_status` = 0 and `rsp_level` = 1. `rsp_paddr` is table-entry bits [31:8] followed by vaddr[13:0]. Control bits [7:2] of either entry have no effect on the result.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr`, `rsp_status` and `rsp_level` hold their values, and no new request is taken.
- R10: During and right after reset, `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base_frame | input | 24 | Frame number of the page directory |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can take a request |
| req_vaddr | input | 38 | Logical address to translate |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 38 | Physical address (0 on fault) |
| rsp_status | output | 2 | 0 ok, 1 absent, 2 protection |
| rsp_level | output | 1 | Level where the walk ended (0 directory, 1 table) |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 38 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid, one-cycle pulse |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
Each result has a fixed cycle in which it is due:

- The directory read request is raised in the cycle after the request handshake.
- The table read request is raised in the cycle after the directory data pulse.
- The response becomes valid in the cycle after the final data pulse, and `req_ready` returns in the cycle after the response handshake.

The bench drives all inputs and samples all outputs on the falling edge. This places every observation half a cycle after the rising edge that produced it. The memory model grants reads and returns data after random delays. It checks each read address at the falling edge where it grants the read. The bench also holds responses back for random stretches and checks at each stalled falling edge that nothing changes.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    WS_OK     = 2'd0,
    WS_ABSENT = 2'd1,
    WS_PROT   = 2'd2
  } walk_status_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DIR_REQ,
    S_DIR_WAIT,
    S_TBL_REQ,
    S_TBL_WAIT,
    S_RESP
  } walk_state_t;

  localparam int CTL_PRESENT  = 0;
  localparam int CTL_WRITABLE = 1;
endpackage

// File: rtl/pt_entry_addr.sv
// Byte address of one table entry: frame base plus index times entry size.
module pt_entry_addr #(
  parameter int FRAME_W = 24,
  parameter int IDX_W   = 12,
  parameter int OFF_W   = 14,
  parameter int ESZ_LOG = 2
) (
  input  logic [FRAME_W-1:0]       frame,
  input  logic [IDX_W-1:0]         idx,
  output logic [FRAME_W+OFF_W-1:0] addr
);
  localparam int PA_W = FRAME_W + OFF_W;

  always_comb begin
    addr = {frame, {OFF_W{1'b0}}} + PA_W'({idx, {ESZ_LOG{1'b0}}});
  end
endmodule

// File: rtl/pt_entry_decode.sv
// Splits a page table entry into frame number and the flags the walker uses.
module pt_entry_decode
  import pt_pkg::*;
#(
  parameter int ENTRY_W = 32,
  parameter int FRAME_W = 24
) (
  input  logic [ENTRY_W-1:0] entry,
  output logic [FRAME_W-1:0] frame,
  output logic               present,
  output logic               writable
);
  localparam int CTL_W = ENTRY_W - FRAME_W;

  logic unused_ctl;

  assign frame      = entry[ENTRY_W-1:CTL_W];
  assign present    = entry[CTL_PRESENT];
  assign writable   = entry[CTL_WRITABLE];
  assign unused_ctl = ^entry[CTL_W-1:CTL_WRITABLE+1];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
#(
  parameter int IDX_W   = 12,
  parameter int OFF_W   = 14,
  parameter int FRAME_W = 24,
  parameter int ENTRY_W = 32,
  parameter int ESZ_LOG = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [FRAME_W-1:0]         dir_base_frame,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [2*IDX_W+OFF_W-1:0]   req_vaddr,
  input  logic                       req_write,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [FRAME_W+OFF_W-1:0]   rsp_paddr,
  output logic [1:0]                 rsp_status,
  output logic                       rsp_level,
  output logic                       mem_rd_valid,
  input  logic                       mem_rd_ready,
  output logic [FRAME_W+OFF_W-1:0]   mem_rd_addr,
  input  logic                       mem_rsp_valid,
  input  logic [ENTRY_W-1:0]         mem_rsp_data
);
  localparam int VA_W  = 2 * IDX_W + OFF_W;
  localparam int PA_W  = FRAME_W + OFF_W;
  localparam int TI_LO = OFF_W;
  localparam int DI_LO = OFF_W + IDX_W;

  walk_state_t        state_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [FRAME_W-1:0] base_q;
  logic [FRAME_W-1:0] tframe_q;
  logic [PA_W-1:0]    paddr_q;
  walk_status_t       status_q;
  logic               level_q;

  logic               at_table;
  logic [FRAME_W-1:0] sel_frame;
  logic [IDX_W-1:0]   sel_idx;
  logic [FRAME_W-1:0] ent_frame;
  logic               ent_present;
  logic               ent_writable;

  // The table level needs the frame from the directory entry, the directory level the latched base.
  assign at_table  = (state_q == S_TBL_REQ);
  assign sel_frame = at_table ? tframe_q : base_q;
  assign sel_idx   = at_table ? va_q[TI_LO +: IDX_W] : va_q[DI_LO +: IDX_W];

  pt_entry_addr #(
    .FRAME_W(FRAME_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ESZ_LOG(ESZ_LOG)
  ) u_addr (
    .frame(sel_frame),
    .idx  (sel_idx),
    .addr (mem_rd_addr)
  );

  pt_entry_decode #(
    .ENTRY_W(ENTRY_W), .FRAME_W(FRAME_W)
  ) u_dec (
    .entry   (mem_rsp_data),
    .frame   (ent_frame),
    .present (ent_present),
    .writable(ent_writable)
  );

  assign req_ready    = (state_q == S_IDLE);
  assign mem_rd_valid = (state_q == S_DIR_REQ) || (state_q == S_TBL_REQ);
  assign rsp_valid    = (state_q == S_RESP);
  assign rsp_paddr    = paddr_q;
  assign rsp_status   = status_q;
  assign rsp_level    = level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      va_q     <= '0;
      wr_q     <= 1'b0;
      base_q   <= '0;
      tframe_q <= '0;
      paddr_q  <= '0;
      status_q <= WS_OK;
      level_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          base_q  <= dir_base_frame;
          state_q <= S_DIR_REQ;
        end
        S_DIR_REQ: if (mem_rd_ready) state_q <= S_DIR_WAIT;
        S_DIR_WAIT: if (mem_rsp_valid) begin
          if (!ent_present) begin
            status_q <= WS_ABSENT;
            level_q  <= 1'b0;
            paddr_q  <= '0;
            state_q  <= S_RESP;
          end else begin
            tframe_q <= ent_frame;
            state_q  <= S_TBL_REQ;
          end
        end
        S_TBL_REQ: if (mem_rd_ready) state_q <= S_TBL_WAIT;
        S_TBL_WAIT: if (mem_rsp_valid) begin
          level_q <= 1'b1;
          state_q <= S_RESP;
          if (!ent_present) begin
            status_q <= WS_ABSENT;
            paddr_q  <= '0;
          end else if (wr_q && !ent_writable) begin
            status_q <= WS_PROT;
            paddr_q  <= '0;
          end else begin
            status_q <= WS_OK;
            paddr_q  <= {ent_frame, va_q[OFF_W-1:0]};
          end
        end
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R4: the read request does not move while the memory stalls it
  p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R9: a stalled response is frozen
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
                               && $stable(rsp_status) && $stable(rsp_level));

  // R1: no request is taken while work is in flight
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_rd_valid);

  // R5: a faulting walk never reports an address
  p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status != 2'd0 |-> rsp_paddr == '0);

  // R5: a directory-level fault is only ever an absent fault
  p_dir_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_level |-> rsp_status == 2'd1);

  // R1: after a handshake the walker is busy in the next cycle
  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready && mem_rd_valid);
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int VA_W = 38;
  localparam int PA_W = 38;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [23:0]     dir_base_frame = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic            req_write = 1'b0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b0;
  logic [PA_W-1:0] rsp_paddr;
  logic [1:0]      rsp_status;
  logic            rsp_level;
  logic            mem_rd_valid;
  logic            mem_rd_ready = 1'b0;
  logic [PA_W-1:0] mem_rd_addr;
  logic            mem_rsp_valid = 1'b0;
  logic [31:0]     mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .dir_base_frame(dir_base_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_status(rsp_status), .rsp_level(rsp_level),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  logic [31:0] mem [logic [PA_W-1:0]];
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int rd_cnt = 0;
  logic [PA_W-1:0] exp_dir_addr, exp_tbl_addr;

  function automatic logic [31:0] mrd(logic [PA_W-1:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  function automatic logic [PA_W-1:0] ent_addr(logic [23:0] fr, logic [11:0] ix);
    return ({fr, 14'd0}) + PA_W'(ix) * 4;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Reference walk from the requirements, reading the bench's own memory.
  task automatic ref_walk(input logic [23:0] base, input logic [VA_W-1:0] va, input bit wr,
                          output logic [1:0] st, output bit lvl, output logic [PA_W-1:0] pa,
                          output int reads);
    logic [31:0] de, te;
    exp_dir_addr = ent_addr(base, va[37:26]);
    de = mrd(exp_dir_addr);
    pa = '0;
    if (!de[0]) begin st = 2'd1; lvl = 1'b0; reads = 1; return; end
    exp_tbl_addr = ent_addr(de[31:8], va[25:14]);
    te = mrd(exp_tbl_addr);
    lvl = 1'b1; reads = 2;
    if (!te[0]) st = 2'd1;
    else if (wr && !te[1]) st = 2'd2;
    else begin st = 2'd0; pa = {te[31:8], va[13:0]}; end
  endtask

  // Memory model: random grant delay, random data latency, address checks.
  initial begin
    bit pending = 1'b0;
    int delay = 0;
    logic [PA_W-1:0] paddr_cap = '0;
    forever begin
      @(negedge clk);
      mem_rd_ready  = 1'b0;
      mem_rsp_valid = 1'b0;
      if (pending) begin
        if (delay == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mrd(paddr_cap);
          pending = 1'b0;
        end else delay--;
      end else if (rst_n && mem_rd_valid && ($urandom % 3 != 0)) begin
        mem_rd_ready = 1'b1;
        paddr_cap = mem_rd_addr;
        if (rd_cnt == 0) chk(mem_rd_addr == exp_dir_addr, "R2 dir addr", mem_rd_addr, exp_dir_addr);
        else chk(mem_rd_addr == exp_tbl_addr, "R3 tbl addr", mem_rd_addr, exp_tbl_addr);
        rd_cnt++;
        pending = 1'b1;
        delay = $urandom % 4;
      end
    end
  end

  task automatic walk(input logic [VA_W-1:0] va, input bit wr, input string tag);
    logic [1:0] st; bit lvl; logic [PA_W-1:0] pa; int reads; int hold;
    ref_walk(dir_base_frame, va, wr, st, lvl, pa, reads);
    rd_cnt = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    dir_base_frame = 24'($urandom);  // R2: must not affect this walk
    chk(!req_ready, "R1 busy after take", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_status == st, {tag, " status"}, rsp_status, st);
    chk(rsp_level == lvl, {tag, " level"}, rsp_level, lvl);
    chk(rsp_paddr == pa, {tag, " paddr"}, rsp_paddr, pa);
    chk(rd_cnt == reads, {tag, " read count"}, rd_cnt, reads);
    hold = $urandom % 4;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_status == st && rsp_paddr == pa && rsp_level == lvl && !req_ready,
          "R9 hold", {rsp_valid, rsp_status, rsp_paddr}, {1'b1, st, pa});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R9 release", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic setup(input logic [VA_W-1:0] va, input logic [23:0] tfr, input logic [7:0] dctl,
                       input logic [23:0] lfr, input logic [7:0] lctl);
    mem[ent_addr(dir_base_frame, va[37:26])] = {tfr, dctl};
    mem[ent_addr(tfr, va[25:14])] = {lfr, lctl};
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_valid, "R10 in reset", {req_ready, rsp_valid, mem_rd_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_valid, "R10 after reset", {req_ready, rsp_valid, mem_rd_valid}, 3'b100);

    dir_base_frame = 24'h000010;
    setup(38'h0_0400_1234, 24'h000123, 8'h00, 24'h0000aa, 8'h03);
    walk(38'h0_0400_1234, 1'b0, "R5 dir absent");
    dir_base_frame = 24'h000010;
    setup(38'h0_0800_4321, 24'h000200, 8'h01, 24'h0000bb, 8'hfe);
    walk(38'h0_0800_4321, 1'b0, "R6 tbl absent");
    dir_base_frame = 24'h000010;
    setup(38'h0_0c00_8001, 24'h000300, 8'h01, 24'h0000cc, 8'h01);
    walk(38'h0_0c00_8001, 1'b1, "R7 write prot");
    dir_base_frame = 24'h000010;
    walk(38'h0_0c00_8001, 1'b0, "R7 read ok");
    dir_base_frame = 24'hffffff;
    setup({38{1'b1}}, 24'hfffffe, 8'hfd, 24'hffffff, 8'hff);
    walk({38{1'b1}}, 1'b1, "R8 max addr");
    dir_base_frame = 24'h000000;
    setup(38'h0, 24'h000001, 8'h01, 24'h000002, 8'h03);
    walk(38'h0, 1'b1, "R8 zero addr");

    for (int n = 0; n < 300; n++) begin
      logic [VA_W-1:0] va;
      logic [7:0] dc, lc;
      va = {6'($urandom), 32'($urandom)};
      dir_base_frame = 24'($urandom);
      dc = 8'($urandom); dc[0] = ($urandom % 8 != 0);
      lc = 8'($urandom); lc[0] = ($urandom % 8 != 0);
      setup(va, 24'($urandom), dc, 24'($urandom), lc);
      walk(va, 1'($urandom), "R8 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule